// File: doc/BRIEF.md
# Systolic Matrix Multiplication Array

This block multiplies two N×N unsigned integer matrices on a square grid of identical multiply-accumulate cells. One operand matrix (the "top" matrix `T`) is streamed into the grid along its upper edge and travels downward. The other (the "left" matrix `L`) is streamed in along its left edge and travels rightward. Each cell keeps its own accumulator, so it is stationary for the whole computation. The block produces `C = L × T`, with `C[i][j] = sum over k of L[i][k]·T[k][j]`.

Each edge stream comes from a small sequencing unit. The unit captures its row of `L` or column of `T` when the start is accepted. It holds its own step counter and presents one element per cycle, delayed by its row or column index. Once its data is used up it presents zeros, so every cell eventually sees a complete row and a complete column. Every link between neighbouring cells passes through one register, and all cells run from one clock.

When the compute phase ends, the accumulators shift downward one row per cycle. The bottom row of the grid is presented at the output, so the product matrix leaves the block as a stream of rows.

Top module: `sysMatTop`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done` and `outValid` are all low.
- R2: A cycle in which `start` is high while the block is idle is called the start edge. It begins a compute phase that lasts exactly 3N-2 cycles. During that phase `busy` is high and `outValid` and `done` are low.
- R3: `done` is high for exactly one cycle, which is the first cycle of the unload phase. That cycle immediately follows the last compute cycle.
- R4: The unload phase lasts exactly N cycles, with `outValid` high throughout. In unload cycle u (counting from 0), `outRow` carries row N-1-u of `C`. Element `C[N-1-u][j]` sits at bits `[j*AW +: AW]`, where `AW = 2*DW + clog2(N)`.
- R5: Operands are unsigned. Element `[r][c]` of either matrix sits at bits `[(r*N+c)*DW +: DW]` of `lMat` or `tMat`. Results are exact at full width, including when every operand is at its maximum value.
- R6: A `start` pulse that arrives while `busy` is high is ignored. It changes neither the timing nor the results of the run in progress.
- R7: `lMat` and `tMat` are sampled only at the start edge. Changing them afterwards has no effect on the results of that run.
- R8: After the last unload cycle the block returns to idle, with `busy` low, and accepts a new `start`. Accumulators and in-flight operands are cleared at every start edge, so back-to-back runs give independent results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication (ignored when busy) |
| lMat | input | N*N*DW | Left-edge operand matrix, row-major |
| tMat | input | N*N*DW | Top-edge operand matrix, row-major |
| busy | output | 1 | Compute or unload in progress |
| done | output | 1 | One-cycle pulse on the first unload cycle |
| outValid | output | 1 | `outRow` carries a result row |
| outRow | output | N*AW | One row of the product, column 0 in the low bits |

## Verification
Count cycles from the start edge. Compute cycles fill the windows 0 to 3N-3. The result row for unload cycle u is due in window 3N-2+u, and `busy` falls in window 4N-2. The bench drives inputs on falling edges and compares every output in every window against a table built from these formulas and a product computed in the bench. A late or early row therefore shows up as a miscompare in that window. Some runs pulse `start` and scramble the operand inputs in windows 1 and 2. The expected values for those runs stay those of the captured operands.

// File: rtl/sysMatPkg.sv
package sysMatPkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear; // zero accumulators and in-flight operands
    logic load;  // edge feeders capture their operand vectors
    logic run;   // one systolic step
    logic shift; // move accumulators one row downward
  } ctlStrobes_t;
endpackage

// File: rtl/sysMatCell.sv
module sysMatCell #(
  parameter int DW = 8,
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          run,
  input  logic          shift,
  input  logic [DW-1:0] leftIn,
  input  logic [DW-1:0] topIn,
  input  logic [AW-1:0] accAbove,
  output logic [DW-1:0] rightOut,
  output logic [DW-1:0] downOut,
  output logic [AW-1:0] accOut
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod;
  assign prod = leftIn * topIn;

  // Registered neighbour links: one step of delay per hop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rightOut <= '0;
      downOut  <= '0;
    end else if (clear) begin
      rightOut <= '0;
      downOut  <= '0;
    end else if (run) begin
      rightOut <= leftIn;
      downOut  <= topIn;
    end
  end

  // Stationary accumulator, which doubles as a shift stage during unload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       accOut <= '0;
    else if (clear)  accOut <= '0;
    else if (run)    accOut <= accOut + AW'(prod);
    else if (shift)  accOut <= accAbove;
  end
endmodule

// File: rtl/sysMatFeeder.sv
module sysMatFeeder #(
  parameter int N   = 4,
  parameter int DW  = 8,
  parameter int LAG = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            load,
  input  logic            run,
  input  logic [N*DW-1:0] vecIn,
  output logic [DW-1:0]   dOut
);
  localparam int CW = $clog2(3 * N + 1) + 1;

  logic [N*DW-1:0] vecReg;
  logic [CW-1:0]   stepCnt;
  logic [CW-1:0]   relIdx;
  logic            inWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg  <= '0;
      stepCnt <= '0;
    end else if (load) begin
      vecReg  <= vecIn;
      stepCnt <= '0;
    end else if (run && stepCnt != {CW{1'b1}}) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  // Skew by LAG steps; after the N real values, pad with zeros
  assign relIdx   = stepCnt - CW'(LAG);
  assign inWindow = (stepCnt >= CW'(LAG)) && (relIdx < CW'(N));

  always_comb begin
    dOut = '0;
    for (int k = 0; k < N; k++) begin
      if (inWindow && relIdx == CW'(k)) dOut = vecReg[k*DW +: DW];
    end
  end
endmodule

// File: rtl/sysMatDatapath.sv
module sysMatDatapath
  import sysMatPkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 2 * DW + $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [N*N*DW-1:0] lMat,
  input  logic [N*N*DW-1:0] tMat,
  output logic [N*AW-1:0]   bottomRow
);
  logic [DW-1:0] hLink [N][N+1];
  logic [DW-1:0] vLink [N+1][N];
  logic [AW-1:0] accLink [N+1][N];

  genvar i, j, k;

  // Left-edge sequencers: row i of L, delayed i steps
  generate
    for (i = 0; i < N; i++) begin : g_left
      sysMatFeeder #(.N(N), .DW(DW), .LAG(i)) u_feed (
        .clk(clk), .rstN(rstN), .load(stb.load), .run(stb.run),
        .vecIn(lMat[i*N*DW +: N*DW]), .dOut(hLink[i][0])
      );
    end
  endgenerate

  // Top-edge sequencers: column j of T, delayed j steps
  generate
    for (j = 0; j < N; j++) begin : g_top
      logic [N*DW-1:0] colVec;
      for (k = 0; k < N; k++) begin : g_gather
        assign colVec[k*DW +: DW] = tMat[(k*N+j)*DW +: DW];
      end
      sysMatFeeder #(.N(N), .DW(DW), .LAG(j)) u_feed (
        .clk(clk), .rstN(rstN), .load(stb.load), .run(stb.run),
        .vecIn(colVec), .dOut(vLink[0][j])
      );
      assign accLink[0][j] = '0;
    end
  endgenerate

  // Cell grid
  generate
    for (i = 0; i < N; i++) begin : g_row
      for (j = 0; j < N; j++) begin : g_col
        sysMatCell #(.DW(DW), .AW(AW)) u_cell (
          .clk(clk), .rstN(rstN),
          .clear(stb.clear), .run(stb.run), .shift(stb.shift),
          .leftIn(hLink[i][j]), .topIn(vLink[i][j]),
          .accAbove(accLink[i][j]),
          .rightOut(hLink[i][j+1]), .downOut(vLink[i+1][j]),
          .accOut(accLink[i+1][j])
        );
      end
    end
  endgenerate

  generate
    for (j = 0; j < N; j++) begin : g_out
      assign bottomRow[j*AW +: AW] = accLink[N][j];
    end
  endgenerate
endmodule

// File: rtl/sysMatControl.sv
module sysMatControl
  import sysMatPkg::*;
#(
  parameter int N = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctlStrobes_t stb,
  output logic        busy,
  output logic        done,
  output logic        outValid
);
  localparam int COMP_LAST = 3 * N - 3;
  localparam int UNLD_LAST = N - 1;
  localparam int CW        = $clog2(3 * N + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_COMP, S_UNLD} phase_t;

  phase_t        phase;
  logic [CW-1:0] phaseCnt;
  logic          accept;

  assign accept = (phase == S_IDLE) && start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= S_IDLE;
      phaseCnt <= '0;
    end else begin
      unique case (phase)
        S_IDLE: if (start) begin
          phase    <= S_COMP;
          phaseCnt <= '0;
        end
        S_COMP: if (phaseCnt == CW'(COMP_LAST)) begin
          phase    <= S_UNLD;
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
        S_UNLD: if (phaseCnt == CW'(UNLD_LAST)) begin
          phase    <= S_IDLE;
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.clear = accept;
    stb.load  = accept;
    stb.run   = (phase == S_COMP);
    stb.shift = (phase == S_UNLD);
  end

  assign busy     = (phase != S_IDLE);
  assign outValid = (phase == S_UNLD);
  assign done     = (phase == S_UNLD) && (phaseCnt == '0);
endmodule

// File: rtl/sysMatTop.sv
module sysMatTop
  import sysMatPkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 2 * DW + $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [N*N*DW-1:0] lMat,
  input  logic [N*N*DW-1:0] tMat,
  output logic              busy,
  output logic              done,
  output logic              outValid,
  output logic [N*AW-1:0]   outRow
);
  ctlStrobes_t     stb;
  logic [N*AW-1:0] bottomRow;

  sysMatControl #(.N(N)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .stb(stb),
    .busy(busy), .done(done), .outValid(outValid)
  );

  sysMatDatapath #(.N(N), .DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .lMat(lMat), .tMat(tMat), .bottomRow(bottomRow)
  );

  assign outRow = outValid ? bottomRow : '0;
endmodule

// File: rtl/sysMatTop_chk.sv
module sysMatTop_chk #(
  parameter int N = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic outValid
);
  localparam int CW = $clog2(4 * N + 1) + 1;

  logic [CW-1:0] compCnt;
  logic [CW-1:0] unldCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compCnt <= '0;
      unldCnt <= '0;
    end else begin
      compCnt <= (busy && !outValid) ? compCnt + 1'b1 : '0;
      unldCnt <= outValid ? unldCnt + 1'b1 : '0;
    end
  end

  // R2: compute phase length measured by counter
  p_comp_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> compCnt == CW'(3 * N - 2));

  // R2: start accepted from idle leads to busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy && !outValid);

  // R3: done marks the first unload cycle only
  p_done_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> outValid && unldCnt == '0);

  p_done_once_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_rise_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> done);

  // R4: unload never exceeds N cycles
  p_unld_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> unldCnt < CW'(N));

  // R4: a result row is only presented while busy
  p_valid_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  // R8: end of unload returns to idle
  p_back_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> !busy);
endmodule

bind sysMatTop sysMatTop_chk #(.N(N)) u_chk (
  .clk(clk), .rstN(rstN), .start(start),
  .busy(busy), .done(done), .outValid(outValid)
);

// File: tb/sysMatTop_test.sv
`timescale 1ns/1ps
module sysMatTop_test;
  localparam int N  = 3;
  localparam int DW = 4;
  localparam int AW = 2 * DW + $clog2(N);
  localparam int MW = N * N * DW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] lMat = '0;
  logic [MW-1:0] tMat = '0;
  logic          busy, done, outValid;
  logic [N*AW-1:0] outRow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  int unsigned lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  sysMatTop #(.N(N), .DW(DW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .lMat(lMat), .tMat(tMat),
    .busy(busy), .done(done), .outValid(outValid), .outRow(outRow)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int elem(input logic [MW-1:0] m, input int r, input int c);
    return int'(m[(r*N+c)*DW +: DW]);
  endfunction

  function automatic int prodElem(input logic [MW-1:0] l, input logic [MW-1:0] t,
                                  input int r, input int c);
    int s = 0;
    for (int k = 0; k < N; k++) s += elem(l, r, k) * elem(t, k, c);
    return s;
  endfunction

  function automatic logic [MW-1:0] nextRand();
    logic [MW-1:0] v;
    for (int b = 0; b < MW; b++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      v[b] = lfsr[20];
    end
    return v;
  endfunction

  // One full run; optionally pokes start and scrambles operands mid-run (R6, R7)
  task automatic runOne(input logic [MW-1:0] l, input logic [MW-1:0] t, input bit poke);
    @(negedge clk);
    lMat = l; tMat = t; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= 4 * N - 2; n++) begin
      if (n > 0) @(negedge clk);
      if (n <= 3 * N - 3) begin
        chk("R2 busy", busy, 1);
        chk("R2 outValid", outValid, 0);
        chk("R3 done low", done, 0);
      end else if (n <= 4 * N - 3) begin
        int u = n - (3 * N - 2);
        chk("R4 outValid", outValid, 1);
        chk("R3 done", done, (u == 0) ? 1 : 0);
        for (int c = 0; c < N; c++)
          chk(poke ? "R6/R7 row" : "R4/R5 row", longint'(outRow[c*AW +: AW]),
              prodElem(l, t, N - 1 - u, c));
      end else begin
        chk("R8 busy low", busy, 0);
        chk("R8 outValid low", outValid, 0);
      end
      if (poke && n == 1) begin
        start = 1'b1; lMat = ~l; tMat = nextRand();
      end
      if (poke && n == 2) start = 1'b0;
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] ident;
    ident = '0;
    for (int d = 0; d < N; d++) ident[(d*N+d)*DW +: DW] = DW'(1);
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 outValid after reset", outValid, 0);

    runOne('0, '0, 0);                    // R5 zeros
    runOne({MW{1'b1}}, {MW{1'b1}}, 0);    // R5 max operands
    runOne(ident, nextRand(), 0);         // identity on the left
    runOne(nextRand(), ident, 0);         // identity on the top
    // R5: single non-zero element swept over every position of each matrix
    for (int p = 0; p < N * N; p++) begin
      logic [MW-1:0] one;
      one = '0; one[p*DW +: DW] = {DW{1'b1}};
      runOne(one, {MW{1'b1}}, 0);
      runOne({MW{1'b1}}, one, 0);
    end
    for (int r = 0; r < 150; r++) runOne(nextRand(), nextRand(), r[0]); // R6 R7 R8 back-to-back

    // R6: start held high through a run from idle for one edge only
    runOne({MW{1'b1}}, ident, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule